// File: doc/BRIEF.md
# Dual Limit-Compare Interval Timer

This block puts two identical up-counting timers behind a single auxiliary-register port. Every timer has three registers: a running count, a control word and a limit. On each core clock the count steps up by one. When it equals the limit, it returns to zero on the next edge. Software can write any start value into the count. If the start is above the limit, the count runs up to the top of its range, wraps through zero and then climbs to the limit.

A limit match can latch a pending flag, which drives that timer's level interrupt output. The flag stays set until software writes the control word. Leaving the flag alone gives one-shot behaviour. Rewriting the control word after each event gives periodic ticks. Each timer also has a control bit that makes it pause while the core's halt input is high. With a start of zero and an all-ones limit, the timer is a free-running counter.

Register reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `aux_tmr_pair`

## Requirements
- R1: Timer 0 decodes count at address 0x021, control at 0x022 and limit at 0x023. Timer 1 decodes count at 0x100, control at 0x101 and limit at 0x102. A write to one timer's register leaves every register of the other timer unchanged.
- R2: While a timer is enabled to run and its count differs from its limit, the count goes up by exactly one per clock.
- R3: A write to the count register loads the written value at the next edge. This write wins over the increment or wrap in that cycle.
- R4: When a running timer's count equals its limit, the next count is 0. A limit of 0 therefore keeps the count at 0. With the all-ones limit, 0xFFFFFFFF is followed by 0.
- R5: With control bit 1 set and the halt input high, the count holds its value. With control bit 1 clear, the halt input has no effect on counting.
- R6: A running limit match with control bit 0 set raises the pending flag, read at control bit 3, on the next edge. The timer's irq output equals this flag. A match with bit 0 clear leaves the flag unchanged.
- R7: Once set, the pending flag stays set through further matches and idle cycles. Any write to that timer's control register clears it; that write wins over a match in the same cycle. The write also loads bits 0 and 1.
- R8: Reads of any address outside the six mapped ones return 0. In the control word, bit 2 and bits 31 to 4 read as 0, and writes to them are ignored.
- R9: After reset, both counts read 0, both control words read 0, both limits read 0xFFFFFFFF, and both irq outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; both timers count on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| halted | input | 1 | High while the core is halted |
| aux_addr | input | 12 | Auxiliary register address |
| aux_wr | input | 1 | Write strobe for aux_wdata at aux_addr |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data for aux_addr; 0 when unmapped |
| irq | output | 2 | Level interrupt per timer, bit n for timer n |

## Verification
The hardest case to reach is a collision between a limit match and a software write in the same cycle. Examples are a control write landing on the match cycle of a pending-enabled timer, or a count write arriving exactly when count equals limit. With random 32-bit values these almost never line up. The stimulus therefore keeps limits small and often writes a count just below or equal to the limit, so matches come every few cycles. This lets random control and count writes fall on match cycles many times. Directed sequences also cover the all-ones wrap, the zero limit and the halt qualifier.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned CTL_IE_BIT   = 0;
  localparam int unsigned CTL_NH_BIT   = 1;
  localparam int unsigned CTL_PEND_BIT = 3;

  typedef struct packed {
    logic pend;
    logic nh;
    logic ie;
  } tmr_ctl_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_CTL,
    SEL_LIM
  } tmr_sel_e;

endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter int              DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted,
  input  logic [ADDR_W-1:0] aux_addr,
  input  logic              aux_wr,
  input  logic [DATA_W-1:0] aux_wdata,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_val,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CNT = BASE;
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(BASE + 2);

  tmr_sel_e          sel;
  logic              wr_cnt, wr_ctl, wr_lim;
  logic [DATA_W-1:0] cnt_q, lim_q;
  tmr_ctl_t          ctl_q;
  logic              run;
  logic              lim_hit;

  function automatic logic [DATA_W-1:0] advance(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] lim,
    input logic              go
  );
    if (!go)           return cur;
    else if (cur == lim) return '0;
    else               return DATA_W'(cur + 1'b1);
  endfunction

  function automatic logic [DATA_W-1:0] ctl_image(input tmr_ctl_t c);
    logic [DATA_W-1:0] img;
    img               = '0;
    img[CTL_IE_BIT]   = c.ie;
    img[CTL_NH_BIT]   = c.nh;
    img[CTL_PEND_BIT] = c.pend;
    return img;
  endfunction

  always_comb begin
    sel = SEL_NONE;
    if (aux_addr == A_CNT)      sel = SEL_CNT;
    else if (aux_addr == A_CTL) sel = SEL_CTL;
    else if (aux_addr == A_LIM) sel = SEL_LIM;
  end

  assign wr_cnt  = aux_wr && (sel == SEL_CNT);
  assign wr_ctl  = aux_wr && (sel == SEL_CTL);
  assign wr_lim  = aux_wr && (sel == SEL_LIM);
  assign run     = !(ctl_q.nh && halted);
  assign lim_hit = run && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '1;
      ctl_q <= '0;
    end else begin
      cnt_q <= wr_cnt ? aux_wdata : advance(cnt_q, lim_q, run);
      if (wr_lim) lim_q <= aux_wdata;
      if (wr_ctl) begin
        ctl_q.ie   <= aux_wdata[CTL_IE_BIT];
        ctl_q.nh   <= aux_wdata[CTL_NH_BIT];
        ctl_q.pend <= 1'b0;
      end else if (lim_hit && ctl_q.ie) begin
        ctl_q.pend <= 1'b1;
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_CNT: rd_val = cnt_q;
      SEL_CTL: rd_val = ctl_image(ctl_q);
      SEL_LIM: rd_val = lim_q;
      default: rd_val = '0;
    endcase
  end

  assign rd_hit = (sel != SEL_NONE);
  assign irq    = ctl_q.pend;

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(aux_wdata)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !lim_hit && !wr_cnt) |=> cnt_q == DATA_W'($past(cnt_q) + 1'b1)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_hit && !wr_cnt) |=> cnt_q == '0); // R4
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q)); // R5
  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(lim_hit && ctl_q.ie)); // R6
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ctl) |=> irq); // R7
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !irq); // R7

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
  parameter int N      = 2,
  parameter int DATA_W = 32
) (
  input  logic [N-1:0]        hit,
  input  logic [N*DATA_W-1:0] vals,
  output logic [DATA_W-1:0]   rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) rdata = rdata | vals[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/aux_tmr_pair.sv
module aux_tmr_pair
  import tmr_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter int                DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE0  = 'h021,
  parameter logic [ADDR_W-1:0] BASE1  = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted,
  input  logic [ADDR_W-1:0] aux_addr,
  input  logic              aux_wr,
  input  logic [DATA_W-1:0] aux_wdata,
  output logic [DATA_W-1:0] aux_rdata,
  output logic [1:0]        irq
);

  localparam int N_TMR = 2;

  logic [N_TMR-1:0]        hit;
  logic [N_TMR*DATA_W-1:0] vals;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] B = (i == 0) ? BASE0 : BASE1;
    tmr_unit #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .BASE  (B)
    ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .halted   (halted),
      .aux_addr (aux_addr),
      .aux_wr   (aux_wr),
      .aux_wdata(aux_wdata),
      .rd_hit   (hit[i]),
      .rd_val   (vals[i*DATA_W +: DATA_W]),
      .irq      (irq[i])
    );
  end

  tmr_rdmux #(
    .N     (N_TMR),
    .DATA_W(DATA_W)
  ) u_rdmux (
    .hit  (hit),
    .vals (vals),
    .rdata(aux_rdata)
  );

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) |-> aux_rdata == '0); // R8

endmodule

// File: tb/aux_tmr_pair_test.sv
`timescale 1ns/1ps
module aux_tmr_pair_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halted = 1'b0;
  logic [11:0] aux_addr = '0;
  logic        aux_wr = 1'b0;
  logic [31:0] aux_wdata = '0;
  logic [31:0] aux_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  aux_tmr_pair uut (
    .clk(clk), .rst_n(rst_n), .halted(halted), .aux_addr(aux_addr),
    .aux_wr(aux_wr), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata), .irq(irq)
  );

  // Reference model, written from the requirements
  logic [31:0] m_cnt [2];
  logic [31:0] m_lim [2];
  bit          m_ie [2];
  bit          m_nh [2];
  bit          m_pend [2];

  function automatic logic [11:0] mbase(input int t);
    return (t == 0) ? 12'h021 : 12'h100;
  endfunction

  function automatic logic [31:0] m_next(input logic [31:0] c, input logic [31:0] l, input bit go);
    logic [31:0] r;
    r = c;
    if (go) r = (c == l) ? 32'd0 : c + 32'd1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        m_cnt[t] <= 32'd0; m_lim[t] <= 32'hFFFF_FFFF;
        m_ie[t] <= 1'b0; m_nh[t] <= 1'b0; m_pend[t] <= 1'b0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        bit go, match;
        go    = !(m_nh[t] && halted);
        match = go && (m_cnt[t] == m_lim[t]);
        if (aux_wr && aux_addr == mbase(t)) m_cnt[t] <= aux_wdata;
        else m_cnt[t] <= m_next(m_cnt[t], m_lim[t], go);
        if (aux_wr && aux_addr == mbase(t) + 12'd2) m_lim[t] <= aux_wdata;
        if (aux_wr && aux_addr == mbase(t) + 12'd1) begin
          m_ie[t] <= aux_wdata[0]; m_nh[t] <= aux_wdata[1]; m_pend[t] <= 1'b0;
        end else if (match && m_ie[t]) m_pend[t] <= 1'b1;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r;
    r = 32'd0;
    for (int t = 0; t < 2; t++) begin
      if (a == mbase(t)) r = m_cnt[t];
      if (a == mbase(t) + 12'd1) r = {28'd0, m_pend[t], 1'b0, m_nh[t], m_ie[t]};
      if (a == mbase(t) + 12'd2) r = m_lim[t];
    end
    return r;
  endfunction

  task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    aux_wr = wr; aux_addr = a; aux_wdata = d;
    @(posedge clk); #1;
    aux_wr = 1'b0;
  endtask

  task automatic check_read(input logic [11:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    aux_wr = 1'b0; aux_addr = a;
    #1;
    exp = m_read(a);
    n_chk++;
    if (aux_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, aux_rdata, exp);
    end
  endtask

  task automatic check_irq(input string tag);
    logic [1:0] exp;
    @(negedge clk); #1;
    exp = {m_pend[1], m_pend[0]};
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset values (first read happens a few counts later, model tracks that)
    check_irq("R9");
    check_read(12'h022, "R9");
    check_read(12'h023, "R9");
    check_read(12'h101, "R9");
    check_read(12'h102, "R9");

    // R2 counting, R1 decode of counts
    check_read(12'h021, "R2");
    check_read(12'h100, "R2");

    // R4 free-running wrap at all ones
    step(1, 12'h100, 32'hFFFF_FFFD);
    check_read(12'h100, "R4");
    check_read(12'h100, "R4");
    check_read(12'h100, "R4");

    // R4 limit zero, R6 pending on match with enable
    step(1, 12'h023, 32'd0);
    step(1, 12'h022, 32'h1);
    check_read(12'h021, "R4");
    check_irq("R6");
    check_read(12'h022, "R6");
    // R7 sticky, then cleared by control write; R8 reserved bits ignored
    check_irq("R7");
    step(1, 12'h022, 32'hFFFF_FFF4);
    check_read(12'h022, "R8");
    check_irq("R7");

    // R3 count write on a match cycle; R1 timer 1 writes leave timer 0 alone
    step(1, 12'h102, 32'd5);
    step(1, 12'h100, 32'd5);
    step(1, 12'h100, 32'd40);
    check_read(12'h100, "R3");
    check_read(12'h023, "R1");

    // R5 halt qualifier
    step(1, 12'h101, 32'h2);
    halted = 1'b1;
    step(1, 12'h100, 32'd3);
    check_read(12'h100, "R5");
    check_read(12'h100, "R5");
    step(1, 12'h101, 32'h0);
    check_read(12'h100, "R5");
    halted = 1'b0;

    // R8 unmapped reads
    check_read(12'h024, "R8");
    check_read(12'h020, "R8");
    check_read(12'h103, "R8");
    check_read(12'hFFF, "R8");

    // Random mix with small limits so matches collide with writes
    for (int i = 0; i < 2500; i++) begin
      int op, t;
      logic [31:0] d;
      logic [11:0] a;
      op = $urandom % 9;
      t  = $urandom % 2;
      halted = ($urandom % 3) == 0;
      case (op)
        0, 1: begin
          d = ($urandom % 4 == 0) ? $urandom : m_lim[t] - ($urandom % 3);
          step(1, mbase(t), d);
        end
        2, 3: step(1, mbase(t) + 12'd1, $urandom);
        4: begin
          d = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : ($urandom % 24);
          step(1, mbase(t) + 12'd2, d);
        end
        5: begin
          a = 12'($urandom);
          if (a >= 12'h021 && a <= 12'h023) a = 12'h300;
          if (a >= 12'h100 && a <= 12'h102) a = 12'h301;
          step(1, a, $urandom);
        end
        default: step(0, 12'h000, 32'd0);
      endcase
      case ($urandom % 4)
        0: check_read(mbase(t), "R2");
        1: check_read(mbase(t) + 12'd1, "R7");
        2: check_read(mbase(t) + 12'd2, "R1");
        default: check_read(12'($urandom), "R8");
      endcase
      check_irq("R6");
    end

    finish_run();
  end

endmodule